// File: doc/BRIEF.md
# MESI line state controller

This block tracks the coherence state of one cache line while the local processor reads, writes and refills it in write-back mode. It holds a two-bit state register and the two global cache control bits, cache-disable and no-write. Each access presented on the access port moves the line to its next state. For each access the block also reports whether a write has to be driven onto the external bus, and whether a modified line that is about to be replaced must first be handed to the copy-back path.

A line fill is seen as two events. The first event is the first burst-ready beat, when the per-fill write-back/write-through indication and the page write-through attribute are captured. The second event is the completion of the fill, when the captured values decide whether the line becomes Exclusive or Shared. Lines filled as write-through are held Shared, so every later write to them also goes out on the bus. A soft reset abandons an unfinished fill but leaves the line state and the control bits as they are.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After `rst_n` is low, `line_state` is Invalid, `bus_write` and `copyback_req` are 0, and both `cd_q` and `nw_q` are 1. States are encoded Invalid=2'b00, Shared=2'b01, Exclusive=2'b10, Modified=2'b11. Access kinds on `acc_kind` are READ=2'b00, WRITE=2'b01, FILL_FIRST=2'b10 (first burst-ready beat) and FILL_DONE=2'b11.
- R2: A FILL_DONE that follows an accepted FILL_FIRST, where `fill_wb` was 1 and `page_wt` was 0 at that FILL_FIRST, sets the line to Exclusive.
- R3: A FILL_DONE that follows an accepted FILL_FIRST, where `fill_wb` was 0 or `page_wt` was 1 at that FILL_FIRST, sets the line to Shared.
- R4: `fill_wb` and `page_wt` are sampled only at FILL_FIRST. Their values at FILL_DONE or at any other access have no effect on the resulting state.
- R5: A WRITE to an Exclusive line makes it Modified with `bus_write` 0.
- R6: A READ or WRITE to a Modified line leaves it Modified with `bus_write` 0.
- R7: A WRITE to a Shared line leaves it Shared and raises `bus_write` for one cycle.
- R8: A WRITE to an Invalid line raises `bus_write` and leaves the line Invalid. A READ to an Invalid line leaves it Invalid.
- R9: A READ to a Shared or Exclusive line leaves the state unchanged with `bus_write` 0.
- R10: An accepted FILL_FIRST on a Modified line raises `copyback_req` for one cycle. The line stays Modified until FILL_DONE.
- R11: While `cd_q` is 1, FILL_FIRST is not accepted. A following FILL_DONE then leaves the state unchanged, and no copy-back is requested.
- R12: While `soft_rst` is 1, accesses and control writes are ignored, `line_state`, `cd_q` and `nw_q` keep their values, and any pending fill is dropped, so a later FILL_DONE leaves the state unchanged.
- R13: With `ctl_we` 1, `ctl_cd` and `ctl_nw` load into `cd_q` and `nw_q`. An access in the same cycle still sees the old cache-disable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset: drops a pending fill and ignores the cycle |
| ctl_we | input | 1 | Load the control bits |
| ctl_cd | input | 1 | New cache-disable value |
| ctl_nw | input | 1 | New no-write value |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | Access kind (READ, WRITE, FILL_FIRST, FILL_DONE) |
| page_wt | input | 1 | Page write-through attribute |
| fill_wb | input | 1 | Per-fill write-back indication from the first burst beat |
| line_state | output | 2 | Registered line state |
| line_next | output | 2 | State the line will take at the next edge |
| bus_write | output | 1 | Write must go to the external bus |
| copyback_req | output | 1 | Modified line must be copied back |
| cd_q | output | 1 | Cache-disable bit |
| nw_q | output | 1 | No-write bit |

## Verification
Every registered result — `line_state`, `bus_write`, `copyback_req`, `cd_q` and `nw_q` — is due one clock edge after the access or control write that causes it. The bench drives inputs on the falling edge, waits for the rising edge, and compares all outputs on the next falling edge, so each comparison sees exactly one update. The two pulse flags are 0 again one edge later unless a new access raises them. The bench confirms this by comparing them on every cycle, idle cycles included.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      ST_INV  = 2'b00,
      ST_SHR  = 2'b01,
      ST_EXC  = 2'b10,
      ST_MOD  = 2'b11
   } line_st_t;

   typedef enum logic [1:0] {
      AK_READ  = 2'b00,
      AK_WRITE = 2'b01,
      AK_FIRST = 2'b10,
      AK_DONE  = 2'b11
   } acc_kind_t;

endpackage

// File: rtl/mesi_ctl_regs.sv
module mesi_ctl_regs #(
   parameter int RESET_CD = 1,
   parameter int RESET_NW = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic we,
   input  logic cd_in,
   input  logic nw_in,
   output logic cd_q,
   output logic nw_q
);
   localparam logic CD_INIT = (RESET_CD != 0);
   localparam logic NW_INIT = (RESET_NW != 0);

   generate
      if (RESET_CD < 0 || RESET_CD > 1) begin : g_bad_cd
         $error("RESET_CD must be 0 or 1");
      end
      if (RESET_NW < 0 || RESET_NW > 1) begin : g_bad_nw
         $error("RESET_NW must be 0 or 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cd_q <= CD_INIT;
         nw_q <= NW_INIT;
      end else if (we && !soft_rst) begin
         cd_q <= cd_in;
         nw_q <= nw_in;
      end
   end

   // R12: soft reset keeps the control bits
   p_soft_keeps_ctl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ($stable(cd_q) && $stable(nw_q)));

   // R13: a control write lands one edge later
   p_ctl_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !soft_rst) |=> (cd_q == $past(cd_in) && nw_q == $past(nw_in)));

endmodule

// File: rtl/mesi_fill_track.sv
module mesi_fill_track (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic start,
   input  logic finish,
   input  logic wb_in,
   input  logic pwt_in,
   output logic armed_q,
   output logic excl_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         excl_q  <= 1'b0;
      end else if (soft_rst) begin
         armed_q <= 1'b0;
      end else if (start) begin
         armed_q <= 1'b1;
         excl_q  <= wb_in && !pwt_in;
      end else if (finish) begin
         armed_q <= 1'b0;
      end
   end

   // R4: the fill choice is captured only on the first beat
   p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !soft_rst) |=> (armed_q && excl_q == ($past(wb_in) && !$past(pwt_in))));

   // R12: soft reset drops the pending fill
   p_soft_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !armed_q);

endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
   import mesi_pkg::*;
(
   input  line_st_t  cur,
   input  logic      acc_valid,
   input  acc_kind_t kind,
   input  logic      soft_rst,
   input  logic      cd,
   input  logic      armed,
   input  logic      excl,
   output line_st_t  nxt,
   output logic      bus_wr,
   output logic      cb_req,
   output logic      fill_start,
   output logic      fill_end
);
   always_comb begin
      nxt        = cur;
      bus_wr     = 1'b0;
      cb_req     = 1'b0;
      fill_start = 1'b0;
      fill_end   = 1'b0;
      if (acc_valid && !soft_rst) begin
         unique case (kind)
            AK_READ: begin
               nxt = cur;
            end
            AK_WRITE: begin
               unique case (cur)
                  ST_INV:  bus_wr = 1'b1;
                  ST_SHR:  bus_wr = 1'b1;
                  ST_EXC:  nxt    = ST_MOD;
                  ST_MOD:  nxt    = ST_MOD;
               endcase
            end
            AK_FIRST: begin
               if (!cd) begin
                  fill_start = 1'b1;
                  cb_req     = (cur == ST_MOD);
               end
            end
            AK_DONE: begin
               if (armed) begin
                  fill_end = 1'b1;
                  nxt      = excl ? ST_EXC : ST_SHR;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int RESET_CD = 1,
   parameter int RESET_NW = 1,
   parameter int FLAG_REG = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       ctl_we,
   input  logic       ctl_cd,
   input  logic       ctl_nw,
   input  logic       acc_valid,
   input  logic [1:0] acc_kind,
   input  logic       page_wt,
   input  logic       fill_wb,
   output logic [1:0] line_state,
   output logic [1:0] line_next,
   output logic       bus_write,
   output logic       copyback_req,
   output logic       cd_q,
   output logic       nw_q
);
   localparam logic [1:0] ENC_MOD = 2'(ST_MOD);
   localparam logic [1:0] ENC_SHR = 2'(ST_SHR);
   localparam logic [1:0] ENC_EXC = 2'(ST_EXC);
   localparam logic [1:0] ENC_INV = 2'(ST_INV);

   generate
      if (FLAG_REG < 0 || FLAG_REG > 1) begin : g_bad_flag
         $error("FLAG_REG must be 0 or 1");
      end
   endgenerate

   line_st_t st_q, st_d;
   logic     armed, excl, f_start, f_end, bw_d, cb_d;

   mesi_ctl_regs #(.RESET_CD(RESET_CD), .RESET_NW(RESET_NW)) u_ctl (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .we(ctl_we),
      .cd_in(ctl_cd), .nw_in(ctl_nw), .cd_q(cd_q), .nw_q(nw_q)
   );

   mesi_fill_track u_fill (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .start(f_start), .finish(f_end), .wb_in(fill_wb), .pwt_in(page_wt),
      .armed_q(armed), .excl_q(excl)
   );

   mesi_next_state u_nxt (
      .cur(st_q), .acc_valid(acc_valid), .kind(acc_kind_t'(acc_kind)),
      .soft_rst(soft_rst), .cd(cd_q), .armed(armed), .excl(excl),
      .nxt(st_d), .bus_wr(bw_d), .cb_req(cb_d),
      .fill_start(f_start), .fill_end(f_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_INV;
      else        st_q <= st_d;
   end

   assign line_state = st_q;
   assign line_next  = st_d;

   generate
      if (FLAG_REG != 0) begin : g_flag_reg
         logic bw_q, cb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bw_q <= 1'b0;
               cb_q <= 1'b0;
            end else begin
               bw_q <= bw_d;
               cb_q <= cb_d;
            end
         end
         assign bus_write    = bw_q;
         assign copyback_req = cb_q;

         // R7: write to a Shared line goes to the bus
         p_shared_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !soft_rst && acc_kind == 2'b01 && line_state == ENC_SHR)
            |=> (line_state == ENC_SHR && bus_write));

         // R8: write to an Invalid line goes to the bus without allocation
         p_inv_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !soft_rst && acc_kind == 2'b01 && line_state == ENC_INV)
            |=> (line_state == ENC_INV && bus_write));

         // R10: replacing a Modified line asks for a copy-back and stays Modified
         p_copyback_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && !soft_rst && acc_kind == 2'b10 && !cd_q && line_state == ENC_MOD)
            |=> (copyback_req && line_state == ENC_MOD));

         // R11: no copy-back while the cache is disabled
         p_no_cb_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
            cd_q && !ctl_we |=> !copyback_req);
      end else begin : g_flag_comb
         assign bus_write    = bw_d;
         assign copyback_req = cb_d;
      end
   endgenerate

   // R5: write to an Exclusive line dirties it silently
   p_exc_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !soft_rst && acc_kind == 2'b01 && line_state == ENC_EXC)
      |=> (line_state == ENC_MOD));

   // R6: reads and writes keep a Modified line Modified
   p_mod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !soft_rst && !acc_kind[1] && line_state == ENC_MOD)
      |=> (line_state == ENC_MOD));

   // R12: soft reset keeps the line state
   p_soft_keeps_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> $stable(line_state));

endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb;
   localparam int CLK_PER = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic soft_rst = 0, ctl_we = 0, ctl_cd = 0, ctl_nw = 0;
   logic acc_valid = 0, page_wt = 0, fill_wb = 0;
   logic [1:0] acc_kind = 2'b00;
   logic [1:0] line_state, line_next;
   logic bus_write, copyback_req, cd_q, nw_q;

   int total = 0, bad = 0;
   bit finished = 0;

   logic [1:0] e_st;
   logic e_cd, e_nw, e_bw, e_cb, e_armed, e_excl;

   always #(CLK_PER/2) clk = ~clk;

   mesi_line_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ctl_we(ctl_we),
      .ctl_cd(ctl_cd), .ctl_nw(ctl_nw), .acc_valid(acc_valid),
      .acc_kind(acc_kind), .page_wt(page_wt), .fill_wb(fill_wb),
      .line_state(line_state), .line_next(line_next), .bus_write(bus_write),
      .copyback_req(copyback_req), .cd_q(cd_q), .nw_q(nw_q)
   );

   // reference next state computed from the requirements
   function automatic logic [1:0] ref_state(input logic [1:0] s, input logic v,
         input logic [1:0] k, input logic sr, input logic armed, input logic excl);
      if (!v || sr) return s;
      case (k)
         2'b01:   return (s == 2'b10) ? 2'b11 : s;
         2'b11:   return armed ? (excl ? 2'b10 : 2'b01) : s;
         default: return s;
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " state"}, {6'd0, line_state}, {6'd0, e_st});
      chk({req, " bus_write"}, {7'd0, bus_write}, {7'd0, e_bw});
      chk({req, " copyback"}, {7'd0, copyback_req}, {7'd0, e_cb});
      chk({req, " cd"}, {7'd0, cd_q}, {7'd0, e_cd});
      chk({req, " nw"}, {7'd0, nw_q}, {7'd0, e_nw});
   endtask

   // drive at a falling edge, update the model, check at the next falling edge
   task automatic step(input string req, input logic sr, input logic we,
         input logic cd, input logic nw, input logic v, input logic [1:0] k,
         input logic wt, input logic wb);
      logic [1:0] ns;
      logic nbw, ncb, narmed, nexcl;
      soft_rst = sr; ctl_we = we; ctl_cd = cd; ctl_nw = nw;
      acc_valid = v; acc_kind = k; page_wt = wt; fill_wb = wb;
      ns = ref_state(e_st, v, k, sr, e_armed, e_excl);
      nbw = v && !sr && k == 2'b01 && (e_st == 2'b00 || e_st == 2'b01);
      ncb = v && !sr && k == 2'b10 && !e_cd && e_st == 2'b11;
      narmed = e_armed; nexcl = e_excl;
      if (sr) narmed = 1'b0;
      else if (v && k == 2'b10 && !e_cd) begin narmed = 1'b1; nexcl = wb && !wt; end
      else if (v && k == 2'b11) narmed = 1'b0;
      if (we && !sr) begin e_cd = cd; e_nw = nw; end
      e_st = ns; e_bw = nbw; e_cb = ncb; e_armed = narmed; e_excl = nexcl;
      @(posedge clk);
      @(negedge clk);
      check_all(req);
   endtask

   task automatic acc(input string req, input logic [1:0] k, input logic wt, input logic wb);
      step(req, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, k, wt, wb);
   endtask

   initial begin
      e_st = 2'b00; e_cd = 1; e_nw = 1; e_bw = 0; e_cb = 0; e_armed = 0; e_excl = 0;
      repeat (3) @(negedge clk);
      check_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after release");

      // R11: fills are refused while disabled
      acc("R11 first beat disabled", 2'b10, 1'b0, 1'b1);
      acc("R11 done disabled", 2'b11, 1'b0, 1'b1);
      // R8: read and write to Invalid
      acc("R8 read invalid", 2'b00, 1'b0, 1'b0);
      acc("R8 write invalid", 2'b01, 1'b0, 1'b0);
      // R13: enable the cache; same-cycle access sees old cd
      step("R13 ctl write", 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0, 1'b1);
      acc("R13 done after old-cd beat", 2'b11, 1'b0, 1'b1);
      // R2 and R4: exclusive fill, done-time inputs ignored
      acc("R2 first beat", 2'b10, 1'b0, 1'b1);
      acc("R4 done with other inputs", 2'b11, 1'b1, 1'b0);
      acc("R9 read exclusive", 2'b00, 1'b1, 1'b0);
      acc("R5 write exclusive", 2'b01, 1'b0, 1'b0);
      acc("R6 read modified", 2'b00, 1'b0, 1'b0);
      acc("R6 write modified", 2'b01, 1'b0, 1'b0);
      // R10: replace a Modified line
      acc("R10 first beat modified", 2'b10, 1'b1, 1'b1);
      step("R10 idle keeps modified", 0, 0, 0, 0, 0, 2'b00, 0, 0);
      acc("R3 done page wt", 2'b11, 1'b0, 1'b0);
      acc("R9 read shared", 2'b00, 1'b0, 1'b0);
      acc("R7 write shared", 2'b01, 1'b0, 1'b0);
      acc("R3 first beat wt fill", 2'b10, 1'b0, 1'b0);
      acc("R3 done wt fill", 2'b11, 1'b0, 1'b1);
      // R12: soft reset drops pending fill
      acc("R12 first beat", 2'b10, 1'b0, 1'b1);
      step("R12 soft reset", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b01, 0, 0);
      acc("R12 done after soft reset", 2'b11, 1'b0, 1'b1);

      // constrained random mix
      void'($urandom(32'd20240611));
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom;
         step("R2 R3 R5 R6 R7 R8 R9 R10 R11 R12 R13 random",
              r[3:0] == 4'd0, r[7:4] == 4'd0, r[8] && r[9], r[10],
              r[12:11] != 2'b00, r[14:13], r[15], r[16]);
      end

      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule